// File: doc/BRIEF.md
# Per-CPU Banked Indirect Register Window

This block is the register file of a multi-queue packet engine that several CPUs share. The address space is cut into one 64 KB window per CPU. A few registers are banked, so each window keeps a private copy: the TX and RX queue-select registers, the interrupt cause and mask registers, and a reservation request/result pair. The per-queue descriptor configuration registers are shared. They are reached indirectly: an access lands on the queue named by the select register of the window the access came through. Two CPUs can therefore program different queues at the same time without corrupting each other's selection.

A mode input picks banked or legacy addressing. In legacy mode the window bits of the address are ignored and every access uses the first bank, so only one set of select registers is in effect. Each TX queue also has a transmitted-descriptor counter. A one-cycle strobe per queue increments it, and a read returns its value and clears it. The bus is a single-beat read/write strobe interface, and read data comes back one cycle after the strobe.

Top module: `cpu_bank_regwin`

## Requirements
- R1: In banked mode (`banked_mode`=1) the window index is `req_addr[17:16]` and the register offset is `req_addr[15:0]`. In legacy mode (`banked_mode`=0) `req_addr[17:16]` is ignored and every access uses bank 0.
- R2: TX select (offset 0x000) and RX select (offset 0x004) are banked per window. Each keeps only the low 3 bits of the written data and reads back zero-extended. A write through one window leaves the other windows' selects unchanged.
- R3: Offsets 0x100 (descriptor base), 0x104 (size), 0x108 (index), 0x10C (pending) and 0x110 (prefetch) are 32-bit read/write registers of the TX queue named by the TX select of the accessing window. All windows share the same per-queue storage.
- R4: Offsets 0x120 (descriptor base), 0x124 (size), 0x128 (index) and 0x12C (occupancy threshold) are 32-bit read/write registers of the RX queue named by the RX select of the accessing window.
- R5: Interrupt cause (0x008) and interrupt mask (0x00C) are 32-bit read/write registers banked per window.
- R6: A write to the banked reservation request (0x010) stores the data, which reads back in full. The queue id sits in bits [19:16] and the requested count in bits [13:0]. The banked result register (0x014) then returns min(count, 16). The result register is read-only, and a write to it has no effect.
- R7: TX queue q has a 16-bit transmitted counter, read at offset 0x200+4q in bits [15:0]. It increments (wrapping) on each cycle that `tx_sent[q]` is high. A read returns the current value and clears the counter. If a clearing read and a strobe fall in the same cycle, the counter ends at 1.
- R8: A read of an unmapped or misaligned offset (low two bits not zero) returns zero. A write to one changes no register.
- R9: After reset every register, select copy and counter is zero, and `rsp_rdata`/`rsp_valid` are zero. `rsp_valid` pulses and `rsp_rdata` updates exactly one cycle after a read strobe. Otherwise `rsp_rdata` holds. When `req_wr` and `req_rd` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banked_mode | input | 1 | 1: per-CPU windows; 0: legacy single bank |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | 18 | Byte address: window in [17:16], offset in [15:0] |
| req_wdata | input | 32 | Write data |
| tx_sent | input | 8 | Per-TX-queue one-cycle transmitted strobe |
| rsp_rdata | output | 32 | Registered read data |
| rsp_valid | output | 1 | High one cycle after an accepted read |

## Verification
The bench sets different select values in several windows. It then confirms that shared queue registers written through one window are seen through another window only when that window selects the same queue. A design that resolved indirect accesses through a global select would return the wrong queue's contents. Legacy mode is exercised with non-zero window bits; a design that kept decoding the window there would leave bank 0 untouched. The counter case with a clearing read and a strobe in the same cycle is driven explicitly. A design that gave the clear priority reads back 0, and one that dropped the clear keeps counting. Misaligned and unmapped writes, and writes to the read-only result register, are each followed by reads that show nothing changed.

// File: rtl/cpu_bank_regwin_pkg.sv
package cpu_bank_regwin_pkg;
  parameter int CPU_MAX   = 4;
  parameter int TXQ_N     = 8;
  parameter int RXQ_N     = 8;
  parameter int DW        = 32;
  parameter int OFF_W     = 16;
  parameter int CNT_W     = 16;
  parameter int RSV_CAP   = 16;
  parameter int RSV_CNT_W = 14;
  parameter int TXF_N     = 5;
  parameter int RXF_N     = 4;

  localparam int WIN_W  = $clog2(CPU_MAX);
  localparam int ADDR_W = OFF_W + WIN_W;
  localparam int TXQ_W  = $clog2(TXQ_N);
  localparam int RXQ_W  = $clog2(RXQ_N);
  localparam int TF_W   = $clog2(TXF_N);
  localparam int RF_W   = $clog2(RXF_N);

  typedef enum logic [3:0] {
    RK_NONE, RK_TXSEL, RK_RXSEL, RK_CAUSE, RK_MASK,
    RK_RSVREQ, RK_RSVRES, RK_TXQ, RK_RXQ, RK_SENT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [5:0] idx;
  } reg_sel_t;

  typedef struct packed {
    logic [TXQ_W-1:0] txsel;
    logic [RXQ_W-1:0] rxsel;
    logic [DW-1:0]    cause;
    logic [DW-1:0]    mask;
    logic [DW-1:0]    rsvreq;
    logic [DW-1:0]    rsvres;
  } bank_t;

  // Offset decode: word-aligned only; page 0 banked, page 1 indirect, page 2 counters
  function automatic reg_sel_t decode_off(input logic [OFF_W-1:0] off);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.idx  = off[7:2];
    if (off[1:0] == 2'b00) begin
      if (off[15:8] == 8'h00) begin
        case (off[7:2])
          6'd0: r.kind = RK_TXSEL;
          6'd1: r.kind = RK_RXSEL;
          6'd2: r.kind = RK_CAUSE;
          6'd3: r.kind = RK_MASK;
          6'd4: r.kind = RK_RSVREQ;
          6'd5: r.kind = RK_RSVRES;
          default: r.kind = RK_NONE;
        endcase
      end else if (off[15:8] == 8'h01) begin
        if (off[7:2] < 6'(TXF_N)) begin
          r.kind = RK_TXQ;
        end else if (off[7:2] >= 6'd8 && off[7:2] < 6'(8 + RXF_N)) begin
          r.kind = RK_RXQ;
          r.idx  = off[7:2] - 6'd8;
        end
      end else if (off[15:8] == 8'h02 && off[7:2] < 6'(TXQ_N)) begin
        r.kind = RK_SENT;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] rsv_grant(input logic [DW-1:0] req);
    logic [RSV_CNT_W-1:0] c;
    c = req[RSV_CNT_W-1:0];
    if (c > RSV_CNT_W'(RSV_CAP)) return DW'(RSV_CAP);
    return DW'(c);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic clr, input logic inc);
    if (clr) return inc ? CNT_W'(1) : '0;
    return cnt + CNT_W'(inc);
  endfunction
endpackage

// File: rtl/cpu_bank_regwin_bank.sv
module cpu_bank_regwin_bank
  import cpu_bank_regwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  reg_kind_e     kind,
  input  logic [DW-1:0] wdata,
  output bank_t         regs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      case (kind)
        RK_TXSEL:  regs.txsel <= wdata[TXQ_W-1:0];
        RK_RXSEL:  regs.rxsel <= wdata[RXQ_W-1:0];
        RK_CAUSE:  regs.cause <= wdata;
        RK_MASK:   regs.mask  <= wdata;
        RK_RSVREQ: begin
          regs.rsvreq <= wdata;
          regs.rsvres <= rsv_grant(wdata);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpu_bank_regwin_qstore.sv
module cpu_bank_regwin_qstore
  import cpu_bank_regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_kind_e        kind,
  input  logic [5:0]       idx,
  input  logic [TXQ_W-1:0] txq,
  input  logic [RXQ_W-1:0] rxq,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    tx_rd,
  output logic [DW-1:0]    rx_rd
);
  logic [DW-1:0] txm [TXQ_N][TXF_N];
  logic [DW-1:0] rxm [RXQ_N][RXF_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < TXQ_N; q++)
        for (int f = 0; f < TXF_N; f++) txm[q][f] <= '0;
      for (int q = 0; q < RXQ_N; q++)
        for (int f = 0; f < RXF_N; f++) rxm[q][f] <= '0;
    end else if (we) begin
      if (kind == RK_TXQ) txm[txq][idx[TF_W-1:0]] <= wdata;
      if (kind == RK_RXQ) rxm[rxq][idx[RF_W-1:0]] <= wdata;
    end
  end

  assign tx_rd = (idx < 6'(TXF_N)) ? txm[txq][idx[TF_W-1:0]] : '0;
  assign rx_rd = (idx < 6'(RXF_N)) ? rxm[rxq][idx[RF_W-1:0]] : '0;
endmodule

// File: rtl/cpu_bank_regwin_sentcnt.sv
module cpu_bank_regwin_sentcnt
  import cpu_bank_regwin_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TXQ_N-1:0]            inc,
  input  logic [TXQ_N-1:0]            clr,
  output logic [TXQ_N-1:0][CNT_W-1:0] cnt
);
  for (genvar q = 0; q < TXQ_N; q++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[q] <= '0;
      else        cnt[q] <= next_count(cnt[q], clr[q], inc[q]);
    end
  end
endmodule

// File: rtl/cpu_bank_regwin.sv
module cpu_bank_regwin
  import cpu_bank_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              banked_mode,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [TXQ_N-1:0]  tx_sent,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_valid
);
  logic [WIN_W-1:0] win;
  reg_sel_t         sel;
  logic             rd_fire;
  logic             unmapped_hit;
  logic [CPU_MAX-1:0] bank_wr;
  bank_t [CPU_MAX-1:0] banks;
  bank_t            cur;
  logic [CPU_MAX-1:0][TXQ_W-1:0] txsel_all;
  logic [DW-1:0]    tx_rd, rx_rd, rd_mux;
  logic [TXQ_N-1:0] sent_clr, sent_inc;
  logic [TXQ_N-1:0][CNT_W-1:0] sent_cnt;

  assign win          = banked_mode ? req_addr[ADDR_W-1:OFF_W] : '0;
  assign sel          = decode_off(req_addr[OFF_W-1:0]);
  assign rd_fire      = req_rd & ~req_wr;
  assign unmapped_hit = (req_rd | req_wr) & (sel.kind == RK_NONE);

  for (genvar i = 0; i < CPU_MAX; i++) begin : g_bank
    assign bank_wr[i]   = req_wr && (win == WIN_W'(i));
    assign txsel_all[i] = banks[i].txsel;
    cpu_bank_regwin_bank u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_wr[i]),
      .kind(sel.kind), .wdata(req_wdata), .regs(banks[i])
    );
  end

  assign cur = banks[win];

  cpu_bank_regwin_qstore u_qstore (
    .clk(clk), .rst_n(rst_n), .we(req_wr), .kind(sel.kind), .idx(sel.idx),
    .txq(cur.txsel), .rxq(cur.rxsel), .wdata(req_wdata),
    .tx_rd(tx_rd), .rx_rd(rx_rd)
  );

  assign sent_clr = (rd_fire && sel.kind == RK_SENT) ? (TXQ_N'(1) << sel.idx) : '0;
  assign sent_inc = tx_sent;

  cpu_bank_regwin_sentcnt u_sent (
    .clk(clk), .rst_n(rst_n), .inc(sent_inc), .clr(sent_clr), .cnt(sent_cnt)
  );

  always_comb begin
    case (sel.kind)
      RK_TXSEL:  rd_mux = DW'(cur.txsel);
      RK_RXSEL:  rd_mux = DW'(cur.rxsel);
      RK_CAUSE:  rd_mux = cur.cause;
      RK_MASK:   rd_mux = cur.mask;
      RK_RSVREQ: rd_mux = cur.rsvreq;
      RK_RSVRES: rd_mux = cur.rsvres;
      RK_TXQ:    rd_mux = tx_rd;
      RK_RXQ:    rd_mux = rx_rd;
      RK_SENT:   rd_mux = DW'(sent_cnt[sel.idx[TXQ_W-1:0]]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cpu_bank_regwin_chk.sv
module cpu_bank_regwin_chk
  import cpu_bank_regwin_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          banked_mode,
  input logic                          req_wr,
  input logic                          rd_fire,
  input logic                          unmapped_hit,
  input logic                          rsp_valid,
  input logic [DW-1:0]                 rsp_rdata,
  input logic [CPU_MAX-1:0]            bank_wr,
  input logic [CPU_MAX-1:0][TXQ_W-1:0] txsel_all,
  input logic [TXQ_N-1:0]              sent_clr,
  input logic [TXQ_N-1:0]              sent_inc,
  input logic [TXQ_N-1:0][CNT_W-1:0]   sent_cnt
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);                                   // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);                                 // R9
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));                                       // R1
  AST_LEGACY_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (!banked_mode && req_wr) |-> bank_wr == CPU_MAX'(1));     // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && unmapped_hit) |=> rsp_rdata == '0);           // R8

  for (genvar i = 0; i < CPU_MAX; i++) begin : g_win
    AST_SEL_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_wr[i] |=> $stable(txsel_all[i]));                 // R2
  end

  for (genvar q = 0; q < TXQ_N; q++) begin : g_q
    AST_SENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sent_clr[q] && !sent_inc[q]) |=> sent_cnt[q] == '0);   // R7
    AST_SENT_CLR_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (sent_clr[q] && sent_inc[q]) |=> sent_cnt[q] == CNT_W'(1)); // R7
    AST_SENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sent_clr[q] && !sent_inc[q]) |=> $stable(sent_cnt[q])); // R7
  end
endmodule

bind cpu_bank_regwin cpu_bank_regwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .banked_mode(banked_mode), .req_wr(req_wr),
  .rd_fire(rd_fire), .unmapped_hit(unmapped_hit), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .bank_wr(bank_wr), .txsel_all(txsel_all),
  .sent_clr(sent_clr), .sent_inc(sent_inc), .sent_cnt(sent_cnt)
);

// File: tb/cpu_bank_regwin_test.sv
module cpu_bank_regwin_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        banked = 1;
  logic        wr = 0, rd = 0;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  sent = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_valid;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R9";
  bit    done = 0;

  always #5 clk = ~clk;

  cpu_bank_regwin uut (
    .clk(clk), .rst_n(rst_n), .banked_mode(banked), .req_wr(wr), .req_rd(rd),
    .req_addr(addr), .req_wdata(wdata), .tx_sent(sent),
    .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_txsel [4], m_rxsel [4], m_cause [4], m_mask [4], m_rreq [4], m_rres [4];
  bit [31:0] m_txcfg [8][5];
  bit [31:0] m_rxcfg [8][4];
  int        m_sent  [8];
  bit [31:0] m_rdata;
  bit        m_valid;

  function automatic bit [31:0] mread(int w, int off);
    if (off % 4 != 0) return 0;
    if (off == 'h0)  return m_txsel[w];
    if (off == 'h4)  return m_rxsel[w];
    if (off == 'h8)  return m_cause[w];
    if (off == 'hC)  return m_mask[w];
    if (off == 'h10) return m_rreq[w];
    if (off == 'h14) return m_rres[w];
    if (off >= 'h100 && off <= 'h110) return m_txcfg[m_txsel[w]][(off - 'h100) / 4];
    if (off >= 'h120 && off <= 'h12C) return m_rxcfg[m_rxsel[w]][(off - 'h120) / 4];
    if (off >= 'h200 && off <= 'h21C) return 32'(m_sent[(off - 'h200) / 4]);
    return 0;
  endfunction

  task automatic mwrite(int w, int off, bit [31:0] d);
    int c;
    if (off % 4 != 0) return;
    if (off == 'h0) m_txsel[w] = d % 8;
    else if (off == 'h4) m_rxsel[w] = d % 8;
    else if (off == 'h8) m_cause[w] = d;
    else if (off == 'hC) m_mask[w] = d;
    else if (off == 'h10) begin
      m_rreq[w] = d;
      c = int'(d & 32'h3FFF);
      m_rres[w] = (c > 16) ? 16 : c;
    end
    else if (off >= 'h100 && off <= 'h110) m_txcfg[m_txsel[w]][(off - 'h100) / 4] = d;
    else if (off >= 'h120 && off <= 'h12C) m_rxcfg[m_rxsel[w]][(off - 'h120) / 4] = d;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_txsel[i] = 0; m_rxsel[i] = 0; m_cause[i] = 0;
        m_mask[i] = 0; m_rreq[i] = 0; m_rres[i] = 0;
      end
      for (int q = 0; q < 8; q++) begin
        for (int f = 0; f < 5; f++) m_txcfg[q][f] = 0;
        for (int f = 0; f < 4; f++) m_rxcfg[q][f] = 0;
        m_sent[q] = 0;
      end
      m_rdata = 0; m_valid = 0;
    end else begin
      int w, off, clrq;
      w    = banked ? int'(addr >> 16) : 0;
      off  = int'(addr & 18'hFFFF);
      clrq = -1;
      m_valid = rd && !wr;
      if (rd && !wr) begin
        m_rdata = mread(w, off);
        if (off % 4 == 0 && off >= 'h200 && off <= 'h21C) clrq = (off - 'h200) / 4;
      end
      if (wr) mwrite(w, off, wdata);
      for (int q = 0; q < 8; q++) begin
        if (q == clrq) m_sent[q] = sent[q] ? 1 : 0;
        else           m_sent[q] = (m_sent[q] + int'(sent[q])) % 65536;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (rsp_valid !== m_valid || rsp_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s cycle compare: valid=%0b rdata=%h expected valid=%0b rdata=%h",
                 cur_req, rsp_valid, rsp_rdata, m_valid, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic bit [17:0] wa(int w, int off);
    return 18'((w << 16) | off);
  endfunction

  task automatic check(string req, bit [31:0] got, bit [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(bit [17:0] a, bit [31:0] d);
    @(negedge clk); wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_exp(bit [17:0] a, bit [31:0] exp, string req, bit [7:0] s = 0);
    @(negedge clk); rd = 1; wr = 0; addr = a; sent = s;
    @(negedge clk); rd = 0; sent = 0;
    check(req, rsp_rdata, exp);
    check(req, 32'(rsp_valid), 1);
  endtask

  task automatic pulse(bit [7:0] s, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sent = s;
    end
    @(negedge clk); sent = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R9";
    check("R9 reset rdata", rsp_rdata, 0);
    check("R9 reset valid", 32'(rsp_valid), 0);
    rst_n = 1;
    rd_exp(wa(0, 'h100), 0, "R9 reset qreg");
    rd_exp(wa(2, 'h8), 0, "R9 reset cause");

    cur_req = "R2";
    do_wr(wa(0, 'h0), 3);
    do_wr(wa(1, 'h0), 5);
    do_wr(wa(2, 'h0), 32'hF);
    rd_exp(wa(0, 'h0), 3, "R2 win0 txsel");
    rd_exp(wa(1, 'h0), 5, "R2 win1 txsel");
    rd_exp(wa(2, 'h0), 7, "R2 win2 txsel low bits");
    rd_exp(wa(3, 'h0), 0, "R2 win3 txsel untouched");

    cur_req = "R3";
    do_wr(wa(0, 'h100), 32'hA000_0000);
    do_wr(wa(1, 'h100), 32'h0000_B000);
    rd_exp(wa(1, 'h100), 32'h0000_B000, "R3 win1 q5 base");
    rd_exp(wa(0, 'h100), 32'hA000_0000, "R3 win0 q3 base");
    rd_exp(wa(3, 'h100), 0, "R3 win3 q0 base");
    do_wr(wa(3, 'h0), 3);
    rd_exp(wa(3, 'h100), 32'hA000_0000, "R3 shared q3 via win3");
    do_wr(wa(0, 'h110), 32'h55);
    rd_exp(wa(3, 'h110), 32'h55, "R3 prefetch shared");

    cur_req = "R4";
    do_wr(wa(0, 'h4), 6);
    do_wr(wa(0, 'h12C), 32'h40);
    do_wr(wa(1, 'h4), 6);
    rd_exp(wa(1, 'h12C), 32'h40, "R4 threshold q6 via win1");
    rd_exp(wa(2, 'h12C), 0, "R4 threshold q0 via win2");

    cur_req = "R5";
    do_wr(wa(2, 'h8), 32'hDEAD);
    do_wr(wa(3, 'hC), 32'h1234);
    rd_exp(wa(2, 'h8), 32'hDEAD, "R5 cause win2");
    rd_exp(wa(0, 'h8), 0, "R5 cause win0 private");
    rd_exp(wa(3, 'hC), 32'h1234, "R5 mask win3");
    rd_exp(wa(2, 'hC), 0, "R5 mask win2 private");

    cur_req = "R6";
    do_wr(wa(1, 'h10), (2 << 16) | 10);
    rd_exp(wa(1, 'h14), 10, "R6 grant below cap");
    rd_exp(wa(1, 'h10), 32'h0002_000A, "R6 request readback");
    do_wr(wa(2, 'h10), (1 << 16) | 100);
    rd_exp(wa(2, 'h14), 16, "R6 grant capped");
    rd_exp(wa(1, 'h14), 10, "R6 win1 result private");
    do_wr(wa(1, 'h14), 99);
    rd_exp(wa(1, 'h14), 10, "R6 result read-only");

    cur_req = "R7";
    pulse(8'h04, 3);
    rd_exp(wa(0, 'h208), 3, "R7 count three");
    rd_exp(wa(0, 'h208), 0, "R7 cleared by read");
    pulse(8'h10, 2);
    rd_exp(wa(2, 'h210), 2, "R7 read with strobe", 8'h10);
    rd_exp(wa(2, 'h210), 1, "R7 clear plus strobe ends at one");

    cur_req = "R8";
    do_wr(wa(0, 'h300), 32'hFFFF_FFFF);
    rd_exp(wa(0, 'h300), 0, "R8 unmapped read");
    do_wr(wa(0, 'h102), 5);
    rd_exp(wa(0, 'h100), 32'hA000_0000, "R8 misaligned write ignored");
    rd_exp(wa(0, 'h18), 0, "R8 unmapped page0");

    cur_req = "R1";
    banked = 0;
    do_wr(wa(3, 'h0), 1);
    rd_exp(wa(1, 'h0), 1, "R1 legacy shared select");
    banked = 1;
    rd_exp(wa(3, 'h0), 3, "R1 win3 untouched in legacy");
    rd_exp(wa(0, 'h0), 1, "R1 legacy hit bank0");

    cur_req = "R9";
    @(negedge clk); wr = 1; rd = 1; addr = wa(0, 'h8); wdata = 32'h77;
    @(negedge clk); wr = 0; rd = 0;
    check("R9 write wins, no valid", 32'(rsp_valid), 0);
    rd_exp(wa(0, 'h8), 32'h77, "R9 write performed");
    @(negedge clk);
    check("R9 rdata holds", rsp_rdata, 32'h77);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule